// File: doc/BRIEF.md
# Clock-Selectable Serial Shift Engine

The block is a small serial engine. An 8-bit data register and a 4-bit bit counter advance on the same clock event. Software selects where that event comes from: the external serial clock pin, a one-cycle software strobe, or a timer compare pulse. The data register holds both the byte to send and the byte received. Each shift moves it one place toward the MSB, and the data-in pin enters at bit 0. The MSB drives the data-out pin through a transparent latch, so the output changes on the serial clock edge opposite the sampling edge.

When the external pin is the source, the pin passes through a two-flop synchroniser. The counter then steps on both of its edges, so sixteen counts make one byte. Its serial clock must run at no more than a quarter of the system clock. When the counter wraps from 15 to 0 it sets a sticky overflow flag, and the flag drives an interrupt request through an enable. A CPU write to the data register or to the counter overrides a shift or count in the same cycle. There is no receive buffer, so software must read each byte before the next one overwrites it.

Top module: `ser_shift_core`

## Requirements
- R1: A CPU write (wr_data high) loads wr_val into data_q at the next clock. This write wins over a shift event in the same cycle.
- R2: On a shift event, data_q becomes {data_q[6:0], din_pin}. With the external pin as source, edge_pol=0 makes the rising pin edge the shift edge and edge_pol=1 makes the falling edge the shift edge.
- R3: With the external source, cnt_q increments on every synchronised pin edge, rising or falling. With the strobe or timer source, cnt_q increments once per shift event. A CPU write (wr_cnt high) loads wr_val[3:0] and wins over the increment.
- R4: An increment from 15 to 0 sets ovf_flag. clr_ovf high clears the flag, but a wrap in the same cycle wins and leaves the flag set.
- R5: irq equals ovf_flag AND irq_en.
- R6: With a source other than the external pin, dout_pin follows data_q[7]. With the external source, dout_pin follows data_q[7] only while the synchronised pin is at the level selected by edge_pol (low for edge_pol=0, high for edge_pol=1); at the other level it holds its last value.
- R7: clk_sel encodes the source as 0 for none, 1 for the external pin, 2 for the software strobe (sw_strobe high for one cycle gives one event) and 3 for the timer pulse (tmr_pulse high gives one event per cycle). Pulses from an unselected source change nothing.
- R8: A level change on sclk_pin, held stable, updates the registers at the third rising system clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock source select |
| edge_pol | input | 1 | External sampling edge: 0 rising, 1 falling |
| sclk_pin | input | 1 | External serial clock |
| din_pin | input | 1 | Serial data in |
| sw_strobe | input | 1 | Software clock strobe |
| tmr_pulse | input | 1 | Timer compare pulse |
| wr_data | input | 1 | CPU write to data register |
| wr_cnt | input | 1 | CPU write to counter |
| wr_val | input | 8 | CPU write value |
| clr_ovf | input | 1 | Write-one clear of overflow flag |
| irq_en | input | 1 | Interrupt enable |
| data_q | output | 8 | Data register readback |
| cnt_q | output | 4 | Counter readback |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |
| dout_pin | output | 1 | Serial data out |

## Verification
A serial clock event and a CPU write can land in the same cycle. So can a counter wrap and a write-one clear of the flag. The bench forces both collisions on purpose: it issues a strobe together with a data or counter write, and it presets the counter to 15 and clears the flag on the wrapping strobe. It also scatters CPU writes at random among external pin edges. A behavioural model decides the outcome from the priority rules and is compared with every output on every cycle.

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    clk_sel,
  input  logic          edge_pol,
  input  logic          sclk_pin,
  input  logic          din_pin,
  input  logic          sw_strobe,
  input  logic          tmr_pulse,
  input  logic          wr_data,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wr_val,
  input  logic          clr_ovf,
  input  logic          irq_en,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_flag,
  output logic          irq,
  output logic          dout_pin
);
  localparam logic [1:0] SRC_PIN = 2'd1, SRC_SW = 2'd2, SRC_TMR = 2'd3;

  logic [2:0] sy;
  logic       hold_q;

  wire ext      = clk_sel == SRC_PIN;
  wire pin_rise = sy[1] & ~sy[2];
  wire pin_fall = ~sy[1] & sy[2];
  wire shift_ev = ext ? (edge_pol ? pin_fall : pin_rise)
                      : ((clk_sel == SRC_SW) & sw_strobe) | ((clk_sel == SRC_TMR) & tmr_pulse);
  wire cnt_ev   = ext ? (pin_rise | pin_fall) : shift_ev;
  wire lat_open = !ext || (sy[1] == edge_pol);
  wire wrap     = cnt_ev && !wr_cnt && (cnt_q == {CW{1'b1}});

  assign dout_pin = lat_open ? data_q[DW-1] : hold_q;
  assign irq      = ovf_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy       <= '0;
      hold_q   <= 1'b0;
      data_q   <= '0;
      cnt_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      sy     <= {sy[1:0], sclk_pin};
      hold_q <= dout_pin;
      if (wr_data)       data_q <= wr_val;
      else if (shift_ev) data_q <= {data_q[DW-2:0], din_pin};
      if (wr_cnt)        cnt_q <= wr_val[CW-1:0];
      else if (cnt_ev)   cnt_q <= cnt_q + 1'b1;
      if (wrap)          ovf_flag <= 1'b1;
      else if (clr_ovf)  ovf_flag <= 1'b0;
    end

  // R1
  wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wr_val));
  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !wr_data) |=> data_q == {$past(data_q[DW-2:0]), $past(din_pin)});
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ev && !wr_cnt) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_open && $past(!lat_open)) |-> $stable(dout_pin));
  // R7
  idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0 && !wr_cnt && !wr_data) |=> ($stable(cnt_q) && $stable(data_q)));
endmodule

// File: tb/sim_ser_shift_core.sv
`timescale 1ns/1ps
module sim_ser_shift_core;
  logic clk = 0, rst_n = 0;
  logic [1:0] clk_sel = 0;
  logic edge_pol = 0, sclk_pin = 0, din_pin = 0, sw_strobe = 0, tmr_pulse = 0;
  logic wr_data = 0, wr_cnt = 0, clr_ovf = 0, irq_en = 0;
  logic [7:0] wr_val = 0;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic ovf_flag, irq, dout_pin;

  int checks = 0, errors = 0;

  ser_shift_core u0 (.clk, .rst_n, .clk_sel, .edge_pol, .sclk_pin, .din_pin,
    .sw_strobe, .tmr_pulse, .wr_data, .wr_cnt, .wr_val, .clr_ovf, .irq_en,
    .data_q, .cnt_q, .ovf_flag, .irq, .dout_pin);

  always #4 clk = ~clk;

  // behavioural model
  bit hist[$] = '{0, 0, 0};
  logic [7:0] m_data = 0;
  int m_cnt = 0;
  bit m_ovf = 0, m_hold = 0;

  function automatic bit exp_dout();
    if (clk_sel == 1 && hist[1] != edge_pol) return m_hold;
    return m_data[7];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0}; m_data = 0; m_cnt = 0; m_ovf = 0; m_hold = 0;
    end else begin
      bit rise, fall, sh, ct, nd;
      rise = hist[1] && !hist[2];
      fall = !hist[1] && hist[2];
      case (clk_sel)
        2'd1: begin sh = edge_pol ? fall : rise; ct = rise || fall; end
        2'd2: begin sh = sw_strobe; ct = sw_strobe; end
        2'd3: begin sh = tmr_pulse; ct = tmr_pulse; end
        default: begin sh = 0; ct = 0; end
      endcase
      nd = exp_dout();
      if (wr_data) m_data = wr_val;
      else if (sh) m_data = {m_data[6:0], din_pin};
      if (wr_cnt) m_cnt = wr_val[3:0];
      else if (ct) begin
        if (m_cnt == 15) begin m_cnt = 0; m_ovf = 1; end
        else begin m_cnt++; if (clr_ovf) m_ovf = 0; end
      end
      if (!(ct && !wr_cnt) && clr_ovf) m_ovf = 0;
      m_hold = nd;
      hist.push_front(sclk_pin);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1/R2 data_q", data_q, m_data);
    chk("R3 cnt_q", cnt_q, m_cnt);
    chk("R4 ovf_flag", ovf_flag, m_ovf);
    chk("R5 irq", irq, m_ovf & irq_en);
    chk("R6 dout_pin", dout_pin, exp_dout());
  end

  task automatic cyc();
    @(negedge clk); #1;
    sw_strobe = 0; tmr_pulse = 0; wr_data = 0; wr_cnt = 0; clr_ovf = 0;
  endtask

  task automatic strobe(bit d);
    cyc(); din_pin = d; sw_strobe = 1;
  endtask

  // R8: each half period is 4 cycles, within the quarter-rate limit
  task automatic ext_run(int halves, bit pol);
    edge_pol = pol;
    for (int i = 0; i < halves; i++) begin
      cyc(); sclk_pin = ~sclk_pin;
      cyc(); din_pin = $urandom_range(0, 1);
      cyc(); cyc();
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 reset data", data_q, 0);
    chk("R3 reset cnt", cnt_q, 0);
    rst_n = 1;
    // R7 strobe source, R2 shifting, R4 wrap
    cyc(); clk_sel = 2; wr_data = 1; wr_val = 8'hA5;
    for (int i = 0; i < 20; i++) strobe($urandom_range(0, 1));
    cyc(); irq_en = 1;
    cyc(); clr_ovf = 1;
    cyc();
    // R1 collision: write and shift together
    cyc(); sw_strobe = 1; wr_data = 1; wr_val = 8'h3C; din_pin = 1;
    // R3 collision: counter write and increment together
    cyc(); sw_strobe = 1; wr_cnt = 1; wr_val = 8'h0E;
    strobe(0);
    // R4 collision: wrap and clear together
    cyc(); sw_strobe = 1; clr_ovf = 1;
    cyc(); cyc(); clr_ovf = 1;
    // R4 clear without wrap
    cyc(); sw_strobe = 1; clr_ovf = 1;
    // R7 timer source
    cyc(); clk_sel = 3;
    for (int i = 0; i < 18; i++) begin cyc(); tmr_pulse = 1; din_pin = i[0]; cyc(); end
    cyc(); tmr_pulse = 1; sw_strobe = 1;
    // R7 no source: pulses ignored
    cyc(); clk_sel = 0;
    for (int i = 0; i < 6; i++) begin cyc(); tmr_pulse = 1; sw_strobe = 1; end
    // R7 strobe ignored while timer selected
    cyc(); clk_sel = 3;
    for (int i = 0; i < 4; i++) strobe(1);
    // R6/R8 external clock, both polarities
    cyc(); clk_sel = 1; sclk_pin = 0;
    cyc(); cyc(); cyc();
    ext_run(34, 0);
    cyc(); wr_data = 1; wr_val = 8'h81;
    ext_run(34, 1);
    // mixed random traffic with writes landing near pin edges
    for (int i = 0; i < 3000; i++) begin
      cyc();
      if (i % 500 == 0) begin clk_sel = $urandom_range(0, 3); edge_pol = $urandom_range(0, 1); end
      if (i % 4 == 0) sclk_pin = ~sclk_pin;
      din_pin = $urandom_range(0, 1);
      sw_strobe = ($urandom_range(0, 3) == 0);
      tmr_pulse = ($urandom_range(0, 3) == 0);
      wr_data = ($urandom_range(0, 15) == 0);
      wr_cnt = ($urandom_range(0, 15) == 0);
      clr_ovf = ($urandom_range(0, 7) == 0);
      irq_en = $urandom_range(0, 1);
      wr_val = $urandom;
    end
    cyc(); cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule